// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block sets the frame timing of a USB host port. It counts PHY clock cycles with a down-counter and raises a one-cycle start-of-frame strobe each time a full interval has passed. The strobe is an SOF in full speed, a micro-SOF in high speed, or a keep-alive strobe in low speed. Each strobe also advances an 11-bit frame number.

Software sets the interval through a 17-bit register write port. Bits 15:0 hold the interval in PHY clocks. Bit 16 enables dynamic reload. Interval writes are accepted only while the port is enabled. The reload bit can be changed only while the port is disabled, so it is fixed once the port runs. Until software programs an interval, the interval comes from the PHY clock-select code and the speed input.

A programmed interval never changes a frame that is already running. It is taken up at an SOF boundary: at every boundary when reload is enabled, and only at the first boundary after enable when reload is disabled.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, `sof` is 0, `frame_num` is 0, and `intv_rd` is 0x0000EA60 when `clk_sel` is 3 and `hs_mode` is 0. The reload bit, `intv_rd[16]`, is 0, and `intv_rd[31:17]` always reads 0.
- R2: Until an interval is programmed, `intv_rd[15:0]` shows the default interval taken from `clk_sel` and `hs_mode`:
  - code 0 gives 48000;
  - code 1 gives 6000;
  - code 2 with `hs_mode`=1 gives 7500;
  - every other combination gives 60000.
- R3: A write made while `port_en` is 0 leaves the interval field unchanged.
- R4: A write made while `port_en` is 0 stores `wr_data[16]` as the reload bit. A write made while `port_en` is 1 leaves the reload bit unchanged, and its `wr_data[15:0]` becomes the programmed interval.
- R5: The first clock edge that samples `port_en` high after it was low starts counting. With interval N, `sof` is high in cycle N after that edge, and then every N cycles.
- R6: `frame_num` increments in the cycle after each `sof` and wraps from 2047 to 0.
- R7: While `port_en` is 0, `frame_num` is held at 0 and `sof` stays low from the cycle after the edge that samples it low.
- R8: With reload enabled, a newly programmed interval changes `act_intv` and the pulse spacing only at the next SOF. The frame already running keeps its length.
- R9: With reload disabled, a write accepted after the first SOF updates `intv_rd`, but `act_intv` and the pulse spacing stay unchanged.
- R10: An interval of 0 is timed as 1, so `sof` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 17 | Bit 16 is the reload enable; bits 15:0 are the interval in PHY clocks |
| port_en | input | 1 | Port enabled flag |
| hs_mode | input | 1 | 1 selects high speed |
| clk_sel | input | 2 | PHY clock-select code |
| sof | output | 1 | One-cycle frame boundary strobe |
| frame_num | output | 11 | Frame number |
| intv_rd | output | 32 | Register readback |
| act_intv | output | 16 | Interval currently being timed |

## Verification
On every cycle, the assertions check four things:
- the frame number steps by exactly one per strobe and holds otherwise;
- the active interval never moves inside a frame;
- disabling the port clears the frame number and the strobe;
- rejected writes leave the interval field and the reload bit untouched.

Only the bench scenarios can show the absolute pulse positions after enable, the spacing that follows a reprogrammed interval in each reload mode, the wrap at 2047, and the default table. The bench computes these from the cycle index.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int IW = 16,
  parameter int FW = 11,
  parameter logic [15:0] RST_INTV = 16'hEA60,
  parameter logic [15:0] INTV_48M = 16'd48000,
  parameter logic [15:0] INTV_6M  = 16'd6000,
  parameter logic [15:0] INTV_HS  = 16'd7500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW:0]   wr_data,
  input  logic          port_en,
  input  logic          hs_mode,
  input  logic [1:0]    clk_sel,
  output logic          sof,
  output logic [FW-1:0] frame_num,
  output logic [31:0]   intv_rd,
  output logic [IW-1:0] act_intv
);

  logic          rld, prog_vld, pen_q, run, first_done;
  logic [IW-1:0] prog, cnt, dflt, cur;

  function automatic logic [IW-1:0] ld(input logic [IW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    case (clk_sel)
      2'd0:    dflt = IW'(INTV_48M);
      2'd1:    dflt = IW'(INTV_6M);
      2'd2:    dflt = hs_mode ? IW'(INTV_HS) : IW'(RST_INTV);
      default: dflt = IW'(RST_INTV);
    endcase
  end

  assign cur     = prog_vld ? prog : dflt;
  assign sof     = run && (cnt == '0);
  assign intv_rd = 32'({rld, cur});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld        <= 1'b0;
      prog       <= IW'(RST_INTV);
      prog_vld   <= 1'b0;
      pen_q      <= 1'b0;
      run        <= 1'b0;
      first_done <= 1'b0;
      cnt        <= '0;
      frame_num  <= '0;
      act_intv   <= IW'(RST_INTV);
    end else begin
      pen_q <= port_en;
      if (wr_en) begin
        if (port_en) begin
          prog     <= wr_data[IW-1:0];
          prog_vld <= 1'b1;
        end else begin
          rld <= wr_data[IW];
        end
      end
      if (!port_en) begin
        run        <= 1'b0;
        first_done <= 1'b0;
        cnt        <= '0;
        frame_num  <= '0;
      end else if (!pen_q) begin
        run      <= 1'b1;
        act_intv <= cur;
        cnt      <= ld(cur);
      end else if (sof) begin
        frame_num  <= frame_num + 1'b1;
        first_done <= 1'b1;
        if (rld || !first_done) begin
          act_intv <= cur;
          cnt      <= ld(cur);
        end else begin
          cnt <= ld(act_intv);
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_frame_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && port_en && pen_q) |=> frame_num == $past(frame_num) + 1'b1);

  p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && port_en && !sof) |=> $stable(frame_num));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (frame_num == '0) && !sof);

  p_no_midframe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && port_en && !sof) |=> $stable(act_intv));

  p_drop_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_en) |=> $stable(prog) && $stable(prog_vld));

  p_rld_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> $stable(rld));

endmodule

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, port_en = 0, hs_mode = 0;
  logic [16:0] wr_data = '0;
  logic [1:0]  clk_sel = 2'd3;
  logic        sof;
  logic [10:0] frame_num;
  logic [31:0] intv_rd;
  logic [15:0] act_intv;
  int errors = 0, checks = 0;
  bit done = 0;

  usb_frame_timer u_dut (.clk, .rst_n, .wr_en, .wr_data, .port_en, .hs_mode,
    .clk_sel, .sof, .frame_num, .intv_rd, .act_intv);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sof", sof, 0);
    chk("R1 frame", frame_num, 0);
    chk("R1 rd", intv_rd, 32'h0000EA60);
    // R2 default table sweep
    for (int h = 0; h < 2; h++)
      for (int c = 0; c < 4; c++) begin
        logic [15:0] e;
        hs_mode = h[0]; clk_sel = c[1:0]; #1;
        e = (c == 0) ? 16'd48000 : (c == 1) ? 16'd6000 : (c == 2 && h == 1) ? 16'd7500 : 16'd60000;
        chk("R2 default", intv_rd[15:0], e);
      end
    hs_mode = 0; clk_sel = 2'd1;
    // R3/R4 write while disabled
    @(negedge clk); wr_en = 1; wr_data = {1'b1, 16'd5};
    @(negedge clk); wr_en = 0;
    chk("R3 interval ignored", intv_rd[15:0], 16'd6000);
    chk("R4 reload set", intv_rd[16], 1);
    chk("R1 upper zero", intv_rd[31:17], 0);
    // R5/R6/R8 enable with default 6000, reprogram to 4 mid-frame
    port_en = 1;
    for (int k = 1; k <= 14200; k++) begin
      @(negedge clk);
      wr_en = 0;
      if (k <= 6000) begin
        chk("R5 sof", sof, k == 6000);
        chk("R6 frame", frame_num, 0);
      end else begin
        chk("R8 sof", sof, ((k - 6000) % 4) == 0);
        chk("R6 frame", frame_num, ((k - 6001) / 4 + 1) % 2048);
      end
      if (k == 20) begin
        chk("R8 rd updated", intv_rd, 32'h00010004);
        chk("R8 active held", act_intv, 6000);
        chk("R4 reload kept", intv_rd[16], 1);
      end
      if (k == 6001) chk("R8 active new", act_intv, 4);
      if (k == 10) begin wr_en = 1; wr_data = {1'b0, 16'd4}; end
    end
    // R7 disable
    port_en = 0;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7 frame", frame_num, 0);
      chk("R7 sof", sof, 0);
    end
    // R9 reload off
    wr_en = 1; wr_data = 17'd0;
    @(negedge clk); wr_en = 0;
    chk("R9 reload clear", intv_rd, 32'h00000004);
    port_en = 1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      wr_en = 0;
      chk("R9 sof", sof, (k % 4) == 0);
      chk("R9 frame", frame_num, (k - 1) / 4);
      if (k == 8) begin
        chk("R9 rd", intv_rd[15:0], 9);
        chk("R9 active", act_intv, 4);
      end
      if (k == 6) begin wr_en = 1; wr_data = {1'b0, 16'd9}; end
    end
    // R10 zero interval with reload on
    port_en = 0;
    @(negedge clk); wr_en = 1; wr_data = {1'b1, 16'd0};
    @(negedge clk); wr_en = 0;
    chk("R4 reload set again", intv_rd, 32'h00010009);
    port_en = 1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      wr_en = 0;
      chk("R10 sof", sof, k >= 9);
      chk("R10 frame", frame_num, (k <= 9) ? 0 : k - 9);
      if (k == 1) begin wr_en = 1; wr_data = 17'd0; end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule